// File: doc/BRIEF.md
# Cell-Flow Traffic Inhibit Controller

This controller brings a cell-based datapath to a quiet state before software reconfigures it. A request bit from the register bank asks for inhibit. The controller then closes four traffic paths: the host-side transmit path, the host-side receive path, the serial transmitter and the active link receive port. The serial transmitter is not stopped. It is told to insert idle cells. Cells arriving on the link receive port are discarded.

Each path closes only at a cell boundary, which is a cycle in which that path reports no cell in progress. The status bit that the processor polls rises only after all four paths have closed. While status is up, software may flush two internal queues. Each flush strobe produces a single one-cycle pulse to its queue.

When the request bit is cleared, status drops in the same cycle. Each path then reopens at its next cell boundary. If the request is withdrawn before the quiesce completes, the controller returns to normal operation and status never rises. Out of reset the controller behaves as though the request bit is set, so the datapath starts in the inhibited state.

Top module: `inhibit_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all four close outputs (`host_tx_stop`, `host_rx_stop`, `ser_idle_ins`, `lnk_rx_discard`) read 1, `inh_status` reads 0 and every `flush_pulse` bit reads 0.
- R2: While `inh_req` is 1, a path's close output goes to 1 at the clock edge where its busy input is 0. It stays 0 for as long as that busy input is 1 at each edge. Once closed, it stays 1 while `inh_req` is 1, whatever the busy input does.
- R3: `inh_status` goes to 1 one cycle after all four close outputs read 1 with `inh_req` held at 1. It is never 1 unless all four close outputs are 1.
- R4: `inh_status` reads 0 in any cycle in which `inh_req` is 0, with no register delay.
- R5: While `inh_req` is 0, a closed path's close output returns to 0 at the clock edge where its busy input is 0. It stays 1 while its busy input is 1.
- R6: If `inh_req` is cleared before all four paths have closed, `inh_status` never rises for that request, and the paths reopen as in R5.
- R7: When bit q of `flush_req` rises while `inh_status` is 1, `flush_pulse[q]` is 1 for exactly one cycle, in the cycle after the edge. A strobe held high produces only that one pulse.
- R8: A `flush_req` bit that rises while `inh_status` is 0 produces no pulse on `flush_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inh_req | input | 1 | Inhibit request bit from the register bank |
| host_tx_busy | input | 1 | Host transmit path has a cell mid-transfer |
| host_rx_busy | input | 1 | Host receive path has a cell mid-transfer |
| ser_tx_busy | input | 1 | Serial transmitter is sending a cell |
| lnk_rx_busy | input | 1 | Link receive port is taking in a cell |
| flush_req | input | NUM_QUEUES | Per-queue flush strobe from the register bank |
| host_tx_stop | output | 1 | Stop the host transmit path |
| host_rx_stop | output | 1 | Stop the host receive path |
| ser_idle_ins | output | 1 | Serial transmitter sends idle cells |
| lnk_rx_discard | output | 1 | Discard cells on the link receive port |
| flush_pulse | output | NUM_QUEUES | One-cycle flush command per queue |
| inh_status | output | 1 | Inhibit is in effect |

## Verification
The hardest case to reach from the ports is a quiesce that is still draining when the request is withdrawn. One path must be held mid-cell while the others close, and the request must drop before that path reaches a boundary. A directed sequence holds one busy input high across the request toggle and tracks status over every cycle of that window. A second directed sequence holds one path busy for several cycles to show that status waits for the slowest path. Random stimulus then starts cells only on paths that are open, toggles the request rarely and strobes the flush inputs often. This mixes cancelled drains, completed drains and flushes arriving on both sides of the status edge.

// File: rtl/inh_pkg.sv
package inh_pkg;

    localparam int NUM_SIDES = 4;
    localparam int SIDE_HOST_TX = 0;
    localparam int SIDE_HOST_RX = 1;
    localparam int SIDE_SER_TX  = 2;
    localparam int SIDE_LNK_RX  = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HALT  = 2'd2
    } inh_state_e;

    typedef struct packed {
        logic       req;
        logic       all_closed;
        inh_state_e state;
    } seq_in_t;

    function automatic logic gate_next(input logic req, input logic closed, input logic busy);
        logic nxt;
        if (req) nxt = closed | ~busy;
        else     nxt = closed & busy;
        return nxt;
    endfunction

    function automatic inh_state_e seq_next(input seq_in_t s);
        inh_state_e nxt;
        nxt = s.state;
        case (s.state)
            ST_RUN:   if (s.req) nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (!s.req)            nxt = ST_RUN;
                else if (s.all_closed) nxt = ST_HALT;
            end
            ST_HALT:  if (!s.req) nxt = ST_RUN;
            default:  nxt = ST_DRAIN;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/inh_side_gate.sv
module inh_side_gate
    import inh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic busy,
    output logic closed
);
    always_ff @(posedge clk) begin
        if (rst) closed <= 1'b1;
        else     closed <= gate_next(req, closed, busy);
    end
endmodule

// File: rtl/inh_seq.sv
module inh_seq
    import inh_pkg::*;
#(
    parameter int SIDES = NUM_SIDES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [SIDES-1:0] closed_vec,
    output logic             status
);
    inh_state_e state;
    seq_in_t    sin;

    always_comb begin
        sin.req        = req;
        sin.all_closed = &closed_vec;
        sin.state      = state;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DRAIN;
        else     state <= seq_next(sin);
    end

    assign status = (state == ST_HALT) && req;
endmodule

// File: rtl/inh_flush_pulser.sv
module inh_flush_pulser (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic strobe,
    output logic pulse
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            strobe_q <= strobe;
            pulse    <= strobe & ~strobe_q & enable;
        end
    end
endmodule

// File: rtl/inhibit_ctrl.sv
module inhibit_ctrl
    import inh_pkg::*;
#(
    parameter int NUM_QUEUES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inh_req,
    input  logic                  host_tx_busy,
    input  logic                  host_rx_busy,
    input  logic                  ser_tx_busy,
    input  logic                  lnk_rx_busy,
    input  logic [NUM_QUEUES-1:0] flush_req,
    output logic                  host_tx_stop,
    output logic                  host_rx_stop,
    output logic                  ser_idle_ins,
    output logic                  lnk_rx_discard,
    output logic [NUM_QUEUES-1:0] flush_pulse,
    output logic                  inh_status
);
    logic [NUM_SIDES-1:0] busy_vec;
    logic [NUM_SIDES-1:0] closed_vec;

    always_comb begin
        busy_vec[SIDE_HOST_TX] = host_tx_busy;
        busy_vec[SIDE_HOST_RX] = host_rx_busy;
        busy_vec[SIDE_SER_TX]  = ser_tx_busy;
        busy_vec[SIDE_LNK_RX]  = lnk_rx_busy;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        inh_side_gate u_gate (
            .clk    (clk),
            .rst    (rst),
            .req    (inh_req),
            .busy   (busy_vec[s]),
            .closed (closed_vec[s])
        );
    end

    inh_seq #(.SIDES(NUM_SIDES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (inh_req),
        .closed_vec (closed_vec),
        .status     (inh_status)
    );

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_flush
        inh_flush_pulser u_fp (
            .clk    (clk),
            .rst    (rst),
            .enable (inh_status),
            .strobe (flush_req[q]),
            .pulse  (flush_pulse[q])
        );
    end

    assign host_tx_stop   = closed_vec[SIDE_HOST_TX];
    assign host_rx_stop   = closed_vec[SIDE_HOST_RX];
    assign ser_idle_ins   = closed_vec[SIDE_SER_TX];
    assign lnk_rx_discard = closed_vec[SIDE_LNK_RX];
endmodule

// File: rtl/inhibit_ctrl_chk.sv
module inhibit_ctrl_chk #(
    parameter int SIDES      = 4,
    parameter int NUM_QUEUES = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req,
    input logic [SIDES-1:0]      busy,
    input logic [SIDES-1:0]      stops,
    input logic [NUM_QUEUES-1:0] flush_req,
    input logic [NUM_QUEUES-1:0] flush_pulse,
    input logic                  status
);
    p_status_all_closed_r3: assert property (@(posedge clk) disable iff (rst)
        status |-> (&stops));

    p_status_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(&stops));

    p_status_drops_r4: assert property (@(posedge clk) disable iff (rst)
        !req |-> !status);

    for (genvar s = 0; s < SIDES; s++) begin : g_side_chk
        p_close_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(stops[s]) |-> $past(req && !busy[s]));

        p_reopen_at_boundary_r5: assert property (@(posedge clk) disable iff (rst)
            $fell(stops[s]) |-> $past(!req && !busy[s]));
    end

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_q_chk
        p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
            flush_pulse[q] |=> !flush_pulse[q]);

        p_flush_gated_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(flush_pulse[q]) |-> $past(status && flush_req[q]));
    end
endmodule

bind inhibit_ctrl inhibit_ctrl_chk #(
    .SIDES      (inh_pkg::NUM_SIDES),
    .NUM_QUEUES (NUM_QUEUES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (inh_req),
    .busy        (busy_vec),
    .stops       (closed_vec),
    .flush_req   (flush_req),
    .flush_pulse (flush_pulse),
    .status      (inh_status)
);

// File: tb/sim_inhibit_ctrl.sv
module sim_inhibit_ctrl;
    localparam int NQ = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          req;
    logic [3:0]    busy;
    logic [NQ-1:0] fl_req;
    logic [3:0]    stop;
    logic [NQ-1:0] fl_pulse;
    logic          status;

    inhibit_ctrl #(.NUM_QUEUES(NQ)) u0 (
        .clk            (clk),
        .rst            (rst),
        .inh_req        (req),
        .host_tx_busy   (busy[0]),
        .host_rx_busy   (busy[1]),
        .ser_tx_busy    (busy[2]),
        .lnk_rx_busy    (busy[3]),
        .flush_req      (fl_req),
        .host_tx_stop   (stop[0]),
        .host_rx_stop   (stop[1]),
        .ser_idle_ins   (stop[2]),
        .lnk_rx_discard (stop[3]),
        .flush_pulse    (fl_pulse),
        .inh_status     (status)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0]    m_closed;
    int            m_st;
    logic [NQ-1:0] m_prev;
    logic [NQ-1:0] m_fl;
    int            pulse_cnt [NQ];
    bit            saw_status;

    function automatic logic m_status(input int st, input logic r);
        return (st == 2) && r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic so;
        logic allc;
        if (rst) begin
            m_closed = 4'hF;
            m_st     = 1;
            m_prev   = '0;
            m_fl     = '0;
        end else begin
            so     = m_status(m_st, req);
            m_fl   = fl_req & ~m_prev & {NQ{so}};
            m_prev = fl_req;
            allc   = &m_closed;
            for (int i = 0; i < 4; i++)
                m_closed[i] = req ? (m_closed[i] | ~busy[i]) : (m_closed[i] & busy[i]);
            case (m_st)
                0: if (req) m_st = 1;
                1: if (!req) m_st = 0; else if (allc) m_st = 2;
                default: if (!req) m_st = 0;
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        if (rst) begin
            chk("R1 stops", {28'd0, stop}, 32'hF);
            chk("R1 status", {31'd0, status}, 32'd0);
            chk("R1 flush", {30'd0, fl_pulse}, 32'd0);
        end else begin
            chk(req ? "R2 stops" : "R5 stops", {28'd0, stop}, {28'd0, m_closed});
            chk("R3 status", {31'd0, status}, {31'd0, m_status(m_st, req)});
            chk("R7 flush", {30'd0, fl_pulse}, {30'd0, m_fl});
        end
        for (int q = 0; q < NQ; q++) pulse_cnt[q] += int'(fl_pulse[q]);
        if (status) saw_status = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt [4];
        void'($urandom(32'h5EED_1234));
        rst = 1; req = 1; busy = 0; fl_req = 0;
        m_closed = 4'hF; m_st = 1; m_prev = 0; m_fl = 0;
        for (int q = 0; q < NQ; q++) pulse_cnt[q] = 0;
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        @(negedge clk);
        repeat (3) tick();                       // R1 during reset
        rst = 0;
        tick();                                   // R1 first cycle after reset
        chk("R1 stops after reset", {28'd0, stop}, 32'hF);
        tick();
        chk("R3 status from reset", {31'd0, status}, 32'd1);

        // R4: status falls in the same cycle as the request
        req = 0;
        #1;
        chk("R4 status same cycle", {31'd0, status}, 32'd0);
        tick();
        chk("R5 stops reopen", {28'd0, stop}, 32'h0);

        // R2/R3: slow path holds the drain
        busy[1] = 1; req = 1;
        tick();
        chk("R2 busy path open", {28'd0, stop}, 32'hD);
        repeat (3) tick();
        chk("R3 status waits", {31'd0, status}, 32'd0);
        busy[1] = 0;
        tick();
        chk("R2 slow path closed", {28'd0, stop}, 32'hF);
        tick();
        chk("R3 status up", {31'd0, status}, 32'd1);

        // R5: reopen waits for busy
        req = 0; busy[3] = 1;
        tick();
        chk("R5 busy path held", {28'd0, stop}, 32'h8);
        busy[3] = 0;
        tick();
        chk("R5 path reopened", {28'd0, stop}, 32'h0);

        // R6: cancelled drain never raises status
        busy[2] = 1; req = 1; saw_status = 0;
        repeat (3) tick();
        req = 0;
        repeat (2) tick();
        busy[2] = 0;
        repeat (3) tick();
        chk("R6 status never set", {31'd0, saw_status}, 32'd0);
        chk("R6 back to normal", {28'd0, stop}, 32'h0);

        // R8: flush without status
        pulse_cnt[0] = 0; pulse_cnt[1] = 0;
        fl_req = 2'b11;
        repeat (3) tick();
        fl_req = 0;
        tick();
        chk("R8 no pulse q0", pulse_cnt[0], 0);
        chk("R8 no pulse q1", pulse_cnt[1], 0);

        // R7: held strobe gives one pulse
        req = 1;
        repeat (3) tick();
        chk("R7 status before flush", {31'd0, status}, 32'd1);
        pulse_cnt[0] = 0; pulse_cnt[1] = 0;
        fl_req = 2'b01;
        repeat (4) tick();
        fl_req = 2'b10;
        repeat (2) tick();
        fl_req = 0;
        tick();
        chk("R7 single pulse q0", pulse_cnt[0], 1);
        chk("R7 single pulse q1", pulse_cnt[1], 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < 4; i++) begin
                if (cnt[i] > 0) begin
                    cnt[i]--;
                    busy[i] = 1;
                end else if (!m_closed[i] && ($urandom % 3 == 0)) begin
                    busy[i] = 1;
                    cnt[i] = int'($urandom % 4);
                end else begin
                    busy[i] = 0;
                end
            end
            if ($urandom % 40 == 0) req = ~req;
            for (int q = 0; q < NQ; q++) fl_req[q] = ($urandom % 4 == 0);
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule